// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address by adding it to one of four 16-bit segment bases. The base is shifted left by four bits before the addition. The block holds the four bases, for code, stack, data and extra, and software loads them through a simple write port. The effective-address arithmetic is done upstream, so the offset arrives already final.

For every request the block chooses the segment from two things: the kind of access and whether the access is based on the stack or frame pointer. A segment override can replace that default choice for ordinary data accesses. It cannot do so for instruction fetches, which always use the code segment, or for string destinations, which always use the extra segment. The address and the index of the chosen segment come out one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the response flag, address and segment index outputs are zero, and all four segment bases are zero. A data request with offset X then yields address X.
- R2: The address is (base << 4) + offset. It appears on `phys_addr` together with `rsp_valid` high in the cycle after `req_valid` was high, and back-to-back requests give back-to-back responses.
- R3: An access of kind 0 (instruction fetch) always reports segment index 0 (code), whatever the values of `ovr_en`, `ovr_idx` and `stack_base`.
- R4: A kind-1 (data) access with `stack_base` high and no override reports index 1 (stack).
- R5: A kind-1 access with `stack_base` low and no override reports index 2 (data).
- R6: An access of kind 2 (string destination) always reports index 3 (extra), even when an override is present.
- R7: On a kind-1 access with `ovr_en` high, the reported index is `ovr_idx`, and that index selects the base.
- R8: A sum that exceeds 20 bits wraps: the carry out of bit 19 is dropped.
- R9: When `seg_we` is high, base number `seg_widx` takes the value `seg_wdata` at that clock edge. A request in the same cycle still sees the old base, and the next request sees the new one.
- R10: In a cycle after `req_valid` was low, `rsp_valid` is low and `phys_addr` and `seg_used` keep their previous values.
- R11: Access kind 3 follows the data rules: `stack_base` picks stack or data, and an override applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_we | input | 1 | Load enable for a segment base |
| seg_widx | input | 2 | Base to load (0 code, 1 stack, 2 data, 3 extra) |
| seg_wdata | input | 16 | New base value |
| req_valid | input | 1 | Address request strobe |
| acc_kind | input | 2 | 0 fetch, 1 data, 2 string destination, 3 treated as data |
| stack_base | input | 1 | Access is based on the stack or frame pointer |
| ovr_en | input | 1 | A segment override is present |
| ovr_idx | input | 2 | Segment named by the override |
| offset | input | 16 | Final offset within the segment |
| rsp_valid | output | 1 | Address outputs are fresh this cycle |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Index of the segment chosen |

## Verification
The bench builds the block with its default parameters: 16-bit bases and offsets and a four-bit shift, which gives a 20-bit address. With these values a base of FFFF and an offset of FFFF are reachable. Their sum, 0x10FFEF, crosses bit 19 and must come back as 0x0FFEF. The bench also loads a base in the same cycle as a request, to show which side of the write the address uses. It sends overrides to every kind of access, which proves that only the data kinds follow them.

// File: rtl/seg_pkg.sv
// Shared types for the segmented address generator.
// Assumes exactly four segment bases, indexed by a 2-bit code.
package seg_pkg;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_idx_t;

    typedef enum logic [1:0] {
        ACC_FETCH   = 2'd0,
        ACC_DATA    = 2'd1,
        ACC_STR_DST = 2'd2,
        ACC_RSVD    = 2'd3
    } acc_kind_t;

    localparam int NUM_SEGS = 4;

endpackage

// File: rtl/seg_base_file.sv
// Holds the segment base registers, with one write port and one read port.
// Assumes: the read is combinational and shows the value held before any
// write in the same cycle (no bypass). Reset clears every base to zero.
module seg_base_file #(
    parameter int SEG_W  = 16,
    parameter int NSEG   = 4,
    localparam int IDX_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SEG_W-1:0] rd_data
);

    logic [NSEG-1:0][SEG_W-1:0] base_q;

    genvar g;
    generate
        for (g = 0; g < NSEG; g++) begin : g_base
            // Load one base when the write port addresses it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_q[g] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    base_q[g] <= wr_data;
                end
            end
        end
    endgenerate

    // Read mux that returns the registered value.
    always_comb begin
        rd_data = base_q[rd_idx];
    end

    // R9
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (base_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/seg_chooser.sv
// Picks the segment index for one access.
// Fetch always goes to code and a string destination always goes to extra.
// The other kinds go to the override when one is present. Without an
// override they go to stack when the access is stack-pointer based, and to
// data otherwise. Purely combinational.
module seg_chooser
    import seg_pkg::*;
(
    input  logic [1:0] acc_kind,
    input  logic       stack_base,
    input  logic       ovr_en,
    input  logic [1:0] ovr_idx,
    output logic [1:0] seg_sel
);

    acc_kind_t kind;
    seg_idx_t  dflt;

    // Decode the access kind.
    always_comb begin
        kind = acc_kind_t'(acc_kind);
    end

    // Default segment for the data-like kinds.
    always_comb begin
        dflt = stack_base ? SEG_STACK : SEG_DATA;
    end

    // Final choice: the fixed cases first, then the override, then the default.
    always_comb begin
        unique case (kind)
            ACC_FETCH:   seg_sel = SEG_CODE;
            ACC_STR_DST: seg_sel = SEG_EXTRA;
            default:     seg_sel = ovr_en ? ovr_idx : dflt;
        endcase
    end

endmodule

// File: rtl/seg_addr_adder.sv
// Forms base << SHIFT plus offset, truncated to ADDR_W bits.
// The carry out of the top bit is dropped, so the result wraps.
// Assumes OFS_W <= ADDR_W.
module seg_addr_adder #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg_val,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] sum
);

    logic [ADDR_W-1:0] base_ext;
    logic [ADDR_W-1:0] ofs_ext;

    // Place the base above the shift.
    always_comb begin
        base_ext = {seg_val, {SHIFT{1'b0}}};
    end

    generate
        if (ADDR_W > OFS_W) begin : g_pad
            // Zero-extend an offset that is narrower than the address.
            always_comb begin
                ofs_ext = {{(ADDR_W - OFS_W){1'b0}}, ofs};
            end
        end else begin : g_same
            // The offset already fills the address width.
            always_comb begin
                ofs_ext = ofs;
            end
        end
    endgenerate

    // Add modulo 2**ADDR_W.
    always_comb begin
        sum = base_ext + ofs_ext;
    end

endmodule

// File: rtl/seg_addr_gen.sv
// Top of the segmented physical address generator.
// It chooses a segment for each request, reads that base and adds the
// offset. The address and the chosen index are registered, so they appear
// one cycle after req_valid. Base writes take effect at the clock edge, and
// a request in the same cycle uses the old base.
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    localparam int ADDR_W = SEG_W + SHIFT,
    localparam int IDX_W  = $clog2(NUM_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_we,
    input  logic [IDX_W-1:0]  seg_widx,
    input  logic [SEG_W-1:0]  seg_wdata,
    input  logic              req_valid,
    input  logic [1:0]        acc_kind,
    input  logic              stack_base,
    input  logic              ovr_en,
    input  logic [IDX_W-1:0]  ovr_idx,
    input  logic [OFS_W-1:0]  offset,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [IDX_W-1:0]  seg_used
);

    logic [IDX_W-1:0]  sel;
    logic [SEG_W-1:0]  base_val;
    logic [ADDR_W-1:0] addr_next;

    seg_chooser u_choose (
        .acc_kind   (acc_kind),
        .stack_base (stack_base),
        .ovr_en     (ovr_en),
        .ovr_idx    (ovr_idx),
        .seg_sel    (sel)
    );

    seg_base_file #(.SEG_W(SEG_W), .NSEG(NUM_SEGS)) u_bases (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_we),
        .wr_idx  (seg_widx),
        .wr_data (seg_wdata),
        .rd_idx  (sel),
        .rd_data (base_val)
    );

    seg_addr_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_add (
        .seg_val (base_val),
        .ofs     (offset),
        .sum     (addr_next)
    );

    // Response flag, valid for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Capture the address and index on a request and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr <= '0;
            seg_used  <= '0;
        end else if (req_valid) begin
            phys_addr <= addr_next;
            seg_used  <= sel;
        end
    end

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(phys_addr) && $stable(seg_used)));

    // R3
    fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'd0) |=> (seg_used == 2'd0));

    // R6
    strdst_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'd2) |=> (seg_used == 2'd3));

    // R7
    ovr_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'd1 && ovr_en) |=> (seg_used == $past(ovr_idx)));

endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;

    typedef struct {
        logic [19:0] addr;
        logic [1:0]  seg;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_widx = '0;
    logic [15:0] seg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        stack_base = 1'b0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_idx = '0;
    logic [15:0] offset = '0;
    logic        rsp_valid;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit have_last = 1'b0;
    bit done = 1'b0;
    logic [19:0] last_addr;
    logic [1:0]  last_seg;
    logic [15:0] model [4];
    exp_t q[$];

    seg_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_widx(seg_widx),
        .seg_wdata(seg_wdata), .req_valid(req_valid), .acc_kind(acc_kind),
        .stack_base(stack_base), .ovr_en(ovr_en), .ovr_idx(ovr_idx),
        .offset(offset), .rsp_valid(rsp_valid), .phys_addr(phys_addr),
        .seg_used(seg_used)
    );

    always #5 clk = ~clk;

    function automatic logic [1:0] pick(input logic [1:0] k, input logic sb,
                                        input logic oe, input logic [1:0] oi);
        if (k == 2'd0) return 2'd0;
        if (k == 2'd2) return 2'd3;
        if (oe) return oi;
        return sb ? 2'd1 : 2'd2;
    endfunction

    // Drive one request and push the expected response into the queue.
    task automatic issue(input logic [1:0] k, input logic sb, input logic oe,
                         input logic [1:0] oi, input logic [15:0] ofs, input string tag);
        exp_t e;
        logic [1:0] s;
        @(negedge clk);
        seg_we = 1'b0;
        req_valid = 1'b1; acc_kind = k; stack_base = sb;
        ovr_en = oe; ovr_idx = oi; offset = ofs;
        s = pick(k, sb, oe, oi);
        e.seg = s;
        e.addr = 20'(({4'b0, model[s]} << 4) + {4'b0, ofs});
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; seg_we = 1'b0;
        end
    endtask

    task automatic load(input logic [1:0] idx, input logic [15:0] v);
        @(negedge clk);
        req_valid = 1'b0;
        seg_we = 1'b1; seg_widx = idx; seg_wdata = v;
        model[idx] = v;
    endtask

    // Monitor: compare responses against the queue and check hold in idle cycles.
    always @(negedge clk) begin
        if (mon_on) begin
            if (rsp_valid) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R2: response with no request, addr %05h seg %0d expected none",
                             phys_addr, seg_used);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (phys_addr !== e.addr || seg_used !== e.seg) begin
                        errors++;
                        $display("FAIL %s: addr %05h seg %0d expected addr %05h seg %0d",
                                 e.tag, phys_addr, seg_used, e.addr, e.seg);
                    end
                end
                last_addr = phys_addr; last_seg = seg_used; have_last = 1'b1;
            end else if (have_last) begin
                // R10: idle cycle must hold outputs
                checks++;
                if (phys_addr !== last_addr || seg_used !== last_seg) begin
                    errors++;
                    $display("FAIL R10: addr %05h seg %0d expected addr %05h seg %0d",
                             phys_addr, seg_used, last_addr, last_seg);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (rsp_valid !== 1'b0 || phys_addr !== 20'h0 || seg_used !== 2'd0) begin
            errors++;
            $display("FAIL R1: valid %0b addr %05h seg %0d expected 0 00000 0",
                     rsp_valid, phys_addr, seg_used);
        end
        mon_on = 1'b1;
        issue(2'd1, 1'b0, 1'b0, 2'd0, 16'h1234, "R1");
        idle(1);
        // R9: bases loaded
        load(2'd0, 16'h1000); load(2'd1, 16'h2000);
        load(2'd2, 16'h3000); load(2'd3, 16'h4000);
        idle(1);
        issue(2'd0, 1'b0, 1'b0, 2'd0, 16'h0010, "R3");
        issue(2'd0, 1'b1, 1'b1, 2'd2, 16'h0020, "R3");
        issue(2'd1, 1'b1, 1'b0, 2'd0, 16'h0ABC, "R4");
        issue(2'd1, 1'b0, 1'b0, 2'd0, 16'h0DEF, "R5");
        idle(2);
        issue(2'd2, 1'b0, 1'b0, 2'd0, 16'h0100, "R6");
        issue(2'd2, 1'b1, 1'b1, 2'd1, 16'h0200, "R6");
        issue(2'd1, 1'b0, 1'b1, 2'd3, 16'h0300, "R7");
        issue(2'd1, 1'b1, 1'b1, 2'd0, 16'h0400, "R7");
        issue(2'd3, 1'b0, 1'b0, 2'd0, 16'h0500, "R11");
        issue(2'd3, 1'b1, 1'b0, 2'd0, 16'h0600, "R11");
        issue(2'd3, 1'b0, 1'b1, 2'd0, 16'h0700, "R11");
        idle(1);
        // R8: wrap past bit 19
        load(2'd2, 16'hFFFF);
        issue(2'd1, 1'b0, 1'b0, 2'd0, 16'hFFFF, "R8");
        issue(2'd1, 1'b0, 1'b0, 2'd0, 16'h0010, "R8");
        idle(1);
        // R9: same-cycle write sees the old base, the next request the new one
        issue(2'd1, 1'b1, 1'b0, 2'd0, 16'h0044, "R9");
        seg_we = 1'b1; seg_widx = 2'd1; seg_wdata = 16'h5555;
        model[1] = 16'h5555;
        issue(2'd1, 1'b1, 1'b0, 2'd0, 16'h0044, "R9");
        idle(3);
        // R2: a burst of back-to-back requests
        for (int i = 0; i < 6; i++)
            issue(2'(i % 4), i[0], 1'b0, 2'd0, 16'(i * 16'h1111), "R2");
        idle(3);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d responses missing expected 0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2: watchdog expired, done 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule